// File: doc/BRIEF.md
# External Memory Chip-Select Controller with Configuration Lock

This block sits between a host request port and an external asynchronous or synchronous memory bus with four chip-select regions. The top two bits of the host address pick a region. The block then drives that region's active-low chip select, together with an active-low output-enable strobe for reads or an active-low write strobe for writes, on registered pins. The strobes stay asserted for the number of cycles programmed for that region. When they drop, the block raises a one-cycle acknowledge and returns the captured read data.

Each region has an 8-bit configuration byte. It holds a wait-state code in bits [7:4], a synchronous-mode flag in bit 3, a write-permission bit in bit 2 and a data-width code in bits [1:0]. Software reaches these bytes through a small register port. A key register guards them: a configuration byte changes only while the key register holds the unlock value 0xA05F. Writing any other value to the key register locks the bytes again.

Top module: `xbus_csel_ctrl`

## Requirements
- R1: After reset every configuration byte reads 0xF0 (16-cycle access, asynchronous, writes disabled, 8-bit width), the block is locked, all chip selects and strobes are high, req_ready is 1 and wr_err is 0.
- R2: The key register sits at offset 0x20. Writing 0xA05F to it unlocks the block, and writing any other value locks it. A read of offset 0x20 returns 1 in bit 0 when unlocked and 0 when locked.
- R3: The configuration bytes for regions 0..3 sit at offsets 0x00, 0x04, 0x08 and 0x0C and read back in cfg_rdata[7:0], one cycle after the read request. A configuration write made while locked leaves the byte unchanged. Reads are allowed in either state.
- R4: req_addr[23:22] selects the region. During an access exactly the matching bit of mem_cs_n is low, and all bits are high otherwise.
- R5: With wait code w = bits [7:4], an access keeps its strobes asserted for w+2 cycles, and code 0xF saturates at 16. req_ack is a one-cycle pulse in the cycle right after the strobes drop.
- R6: A read drives mem_oe_n low for the whole access and keeps mem_we_n high. req_rdata then holds the value mem_rdata had on the last strobe cycle, from the acknowledge onward.
- R7: A write drives mem_we_n low for the whole access only if bit 2 of the region's byte is 1. When bit 2 is 0, mem_we_n stays high, the access is still acknowledged after its full length, and wr_err becomes 1 and stays 1 until reset.
- R8: During an access, mem_sync shows bit 3 of the region's byte and mem_width shows bits [1:0] (00 = 8-bit, 01 = 16-bit, 10 = 32-bit). The reserved code 11 is shown as 10.
- R9: req_ready is low from acceptance until the acknowledge. A req_valid seen while busy is ignored. mem_addr, mem_wdata and mem_be hold the values captured at acceptance for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Register access strobe |
| cfg_we | input | 1 | 1 = register write, 0 = register read |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Host address; top two bits select the region |
| req_wdata | input | 32 | Host write data |
| req_be | input | 4 | Byte lane enables |
| req_ready | output | 1 | Block idle and able to accept |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data of the last read |
| wr_err | output | 1 | Sticky flag: write attempted to a write-disabled region |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte lanes |
| mem_sync | output | 1 | Synchronous-mode flag of the active region |
| mem_width | output | 2 | Data-width code of the active region |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench measures strobe lengths at both ends of the wait encoding. It uses the shortest code, 0x0 (2 cycles), a mid value (7 cycles), and both 0xE and 0xF, which must give the same 16 cycles. A design with an off-by-one counter, or one that lets 0xF run to 17 cycles, gives the wrong strobe length. The bench tries configuration writes while locked and after a wrong key, where a missing lock check would let a byte change. It also issues a write to a write-disabled region, where a faulty gate would pulse mem_we_n or skip the acknowledge. Finally it sends a second request in the middle of an access and uses the reserved width code, to catch a sequencer that re-latches the address or passes code 11 through unchanged.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // One configuration byte per chip-select region.
  typedef struct packed {
    logic [3:0] wait_code;   // strobe length code
    logic       sync_mode;   // 1 = synchronous memory
    logic       wr_allow;    // 1 = write strobe permitted
    logic [1:0] width_code;  // 00 8-bit, 01 16-bit, 10 32-bit, 11 reserved
  } cs_cfg_t;

  localparam int LEN_W   = 5;
  localparam int MAX_LEN = 16;

  localparam cs_cfg_t CFG_RESET = '{wait_code: 4'hF, sync_mode: 1'b0,
                                    wr_allow: 1'b0, width_code: 2'b00};

  // Strobe length in cycles: code + 2, saturating at MAX_LEN.
  function automatic logic [LEN_W-1:0] access_cycles(input logic [3:0] code);
    logic [LEN_W-1:0] raw;
    raw = {1'b0, code} + LEN_W'(2);
    if (raw > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
    return raw;
  endfunction

  // Reserved width code is presented as 32-bit.
  function automatic logic [1:0] eff_width(input logic [1:0] code);
    return (code == 2'b11) ? 2'b10 : code;
  endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
  import xbus_pkg::*;
#(
  parameter int                  N_CS       = 4,
  parameter int                  CFG_AW     = 6,
  parameter int                  CFG_DW     = 16,
  parameter int                  REG_STRIDE = 4,
  parameter logic [CFG_AW-1:0]   LOCK_OFFS  = 6'h20,
  parameter logic [CFG_DW-1:0]   UNLOCK_KEY = 16'hA05F
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_req,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  output logic [CFG_DW-1:0]     cfg_rdata,
  output cs_cfg_t [N_CS-1:0]    cs_cfg
);

  localparam int CFG_BITS = $bits(cs_cfg_t);

  cs_cfg_t            cfg_q [N_CS];
  logic               unlocked_q;
  logic               lock_hit;
  logic [N_CS-1:0]    reg_hit;
  logic [CFG_DW-1:0]  rd_val;

  assign lock_hit = cfg_req && cfg_we && (cfg_addr == LOCK_OFFS);

  always_ff @(posedge clk) begin
    if (rst)           unlocked_q <= 1'b0;
    else if (lock_hit) unlocked_q <= (cfg_wdata == UNLOCK_KEY);
  end

  generate
    for (genvar g = 0; g < N_CS; g++) begin : g_cfg
      assign reg_hit[g] = (cfg_addr == CFG_AW'(g * REG_STRIDE));

      always_ff @(posedge clk) begin
        if (rst)
          cfg_q[g] <= CFG_RESET;
        else if (cfg_req && cfg_we && reg_hit[g] && unlocked_q)
          cfg_q[g] <= cs_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
      end

      assign cs_cfg[g] = cfg_q[g];
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    if (cfg_addr == LOCK_OFFS) rd_val[0] = unlocked_q;
    for (int k = 0; k < N_CS; k++)
      if (reg_hit[k]) rd_val[CFG_BITS-1:0] = cfg_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)                    cfg_rdata <= '0;
    else if (cfg_req && !cfg_we) cfg_rdata <= rd_val;
  end

  // R3: locked configuration writes leave every byte unchanged
  p_locked_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_we && !unlocked_q && cfg_addr != LOCK_OFFS) |=> $stable(cs_cfg));

  // R2: the key value unlocks, anything else locks
  p_key_unlock_r2: assert property (@(posedge clk) disable iff (rst)
    (lock_hit && cfg_wdata == UNLOCK_KEY) |=> unlocked_q);
  p_key_relock_r2: assert property (@(posedge clk) disable iff (rst)
    (lock_hit && cfg_wdata != UNLOCK_KEY) |=> !unlocked_q);

endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode
  import xbus_pkg::*;
#(
  parameter int N_CS = 4,
  localparam int CS_W = $clog2(N_CS)
) (
  input  logic [CS_W-1:0]       cs_field,
  input  cs_cfg_t [N_CS-1:0]    cs_cfg,
  output logic [N_CS-1:0]       cs_onehot,
  output cs_cfg_t               sel_cfg
);

  generate
    for (genvar g = 0; g < N_CS; g++) begin : g_dec
      assign cs_onehot[g] = (cs_field == CS_W'(g));
    end
  endgenerate

  assign sel_cfg = cs_cfg[cs_field];

endmodule

// File: rtl/xbus_access_seq.sv
module xbus_access_seq
  import xbus_pkg::*;
#(
  parameter int N_CS   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int RUN_W = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [BE_W-1:0]    req_be,
  input  cs_cfg_t            sel_cfg,
  input  logic [N_CS-1:0]    cs_onehot,
  output logic               req_ready,
  output logic               req_ack,
  output logic [DATA_W-1:0]  req_rdata,
  output logic               wr_err,
  output logic [N_CS-1:0]    mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [BE_W-1:0]    mem_be,
  output logic               mem_sync,
  output logic [1:0]         mem_width,
  input  logic [DATA_W-1:0]  mem_rdata
);

  logic             busy_q;
  logic [LEN_W-1:0] cnt_q;
  logic             wr_q;
  logic             allow_q;

  assign req_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      wr_q      <= 1'b0;
      allow_q   <= 1'b0;
      req_ack   <= 1'b0;
      req_rdata <= '0;
      wr_err    <= 1'b0;
      mem_cs_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      mem_sync  <= 1'b0;
      mem_width <= 2'b00;
    end else begin
      req_ack <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q   <= 1'b0;
          mem_cs_n <= '1;
          mem_oe_n <= 1'b1;
          mem_we_n <= 1'b1;
          req_ack  <= 1'b1;
          if (wr_q && !allow_q) wr_err    <= 1'b1;
          if (!wr_q)            req_rdata <= mem_rdata;
        end else begin
          cnt_q <= cnt_q - LEN_W'(1);
        end
      end else if (req_valid) begin
        busy_q    <= 1'b1;
        cnt_q     <= access_cycles(sel_cfg.wait_code) - LEN_W'(1);
        wr_q      <= req_write;
        allow_q   <= sel_cfg.wr_allow;
        mem_cs_n  <= ~cs_onehot;
        mem_oe_n  <= req_write;
        mem_we_n  <= !(req_write && sel_cfg.wr_allow);
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
        mem_be    <= req_be;
        mem_sync  <= sel_cfg.sync_mode;
        mem_width <= eff_width(sel_cfg.width_code);
      end
    end
  end

  // Run-length counter of consecutive chip-select cycles, for the length bound.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                run_q <= '0;
    else if (mem_cs_n != '1) run_q <= run_q + RUN_W'(1);
    else                    run_q <= '0;
  end

  // R5: no strobe run exceeds the saturated length
  p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(MAX_LEN));
  // R5: acknowledge is a single-cycle pulse
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);
  // R4: at most one chip select active
  p_one_cs_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));
  // R4: a strobe is only active under a chip select
  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));
  // R6: read and write strobes never overlap
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);
  // R7: a blocked write never pulls the write strobe
  p_blocked_we_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_q && !allow_q) |-> mem_we_n);
  // R9: captured address held for the whole access
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (!busy_q || $stable(mem_addr)));

endmodule

// File: rtl/xbus_csel_ctrl.sv
module xbus_csel_ctrl
  import xbus_pkg::*;
#(
  parameter int                N_CS       = 4,
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 32,
  parameter int                CFG_AW     = 6,
  parameter int                CFG_DW     = 16,
  parameter logic [CFG_AW-1:0] LOCK_OFFS  = 6'h20,
  parameter logic [CFG_DW-1:0] UNLOCK_KEY = 16'hA05F,
  localparam int               BE_W       = DATA_W / 8,
  localparam int               CS_W       = $clog2(N_CS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_req,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [BE_W-1:0]    req_be,
  output logic               req_ready,
  output logic               req_ack,
  output logic [DATA_W-1:0]  req_rdata,
  output logic               wr_err,
  output logic [N_CS-1:0]    mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [BE_W-1:0]    mem_be,
  output logic               mem_sync,
  output logic [1:0]         mem_width,
  input  logic [DATA_W-1:0]  mem_rdata
);

  cs_cfg_t [N_CS-1:0] cs_cfg;
  cs_cfg_t            sel_cfg;
  logic [N_CS-1:0]    cs_onehot;

  xbus_cfg_regs #(
    .N_CS(N_CS), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .REG_STRIDE(4),
    .LOCK_OFFS(LOCK_OFFS), .UNLOCK_KEY(UNLOCK_KEY)
  ) cfg_regs_i (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cs_cfg(cs_cfg)
  );

  xbus_cs_decode #(.N_CS(N_CS)) decode_i (
    .cs_field(req_addr[ADDR_W-1 -: CS_W]), .cs_cfg(cs_cfg),
    .cs_onehot(cs_onehot), .sel_cfg(sel_cfg)
  );

  xbus_access_seq #(.N_CS(N_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .sel_cfg(sel_cfg), .cs_onehot(cs_onehot), .req_ready(req_ready),
    .req_ack(req_ack), .req_rdata(req_rdata), .wr_err(wr_err),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_sync(mem_sync), .mem_width(mem_width), .mem_rdata(mem_rdata)
  );

endmodule

// File: tb/xbus_csel_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_csel_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, req_ack, wr_err, mem_oe_n, mem_we_n, mem_sync;
  logic [31:0] req_rdata, mem_wdata, mem_rdata;
  logic [3:0]  mem_cs_n, mem_be;
  logic [23:0] mem_addr;
  logic [1:0]  mem_width;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_rdata = {8'hA5, mem_addr};

  xbus_csel_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .req_ack(req_ack), .req_rdata(req_rdata), .wr_err(wr_err),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_sync(mem_sync), .mem_width(mem_width), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_cfg [4];
  bit          m_unl, m_ack, m_err, m_wr, m_allow, m_sync;
  int          m_left, m_cs;
  logic [1:0]  m_width;
  logic [23:0] m_addr;
  logic [31:0] m_wd, m_rdata;
  logic [3:0]  m_be;
  logic [15:0] m_crd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cfg[i]) m_cfg[i] = 8'hF0;
      m_unl = 0; m_ack = 0; m_err = 0; m_left = 0; m_rdata = '0; m_crd = '0;
    end else begin
      m_ack = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_ack = 1;
          if (m_wr && !m_allow) m_err = 1;
          if (!m_wr) m_rdata = {8'hA5, m_addr};
        end
      end else if (req_valid) begin
        int w;
        m_cs    = int'(req_addr[23:22]);
        m_wr    = req_write;
        m_allow = m_cfg[m_cs][2];
        m_sync  = m_cfg[m_cs][3];
        m_width = (m_cfg[m_cs][1:0] == 2'b11) ? 2'b10 : m_cfg[m_cs][1:0];
        w       = int'(m_cfg[m_cs][7:4]);
        m_left  = (w == 15) ? 16 : w + 2;
        m_addr = req_addr; m_wd = req_wdata; m_be = req_be;
      end
      if (cfg_req) begin
        if (cfg_we) begin
          if (cfg_addr == 6'h20) m_unl = (cfg_wdata == 16'hA05F);
          else if (m_unl && cfg_addr < 6'h10 && cfg_addr[1:0] == 2'b00)
            m_cfg[cfg_addr[3:2]] = cfg_wdata[7:0];
        end else begin
          if (cfg_addr == 6'h20) m_crd = {15'b0, m_unl};
          else if (cfg_addr < 6'h10 && cfg_addr[1:0] == 2'b00) m_crd = {8'b0, m_cfg[cfg_addr[3:2]]};
          else m_crd = '0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [3:0] ecs;
      ecs = (m_left > 0) ? ~(4'b1 << m_cs) : 4'hF;
      chk(mem_cs_n == ecs, "R4 cs_n", 32'(mem_cs_n), 32'(ecs));
      chk(mem_oe_n == !(m_left > 0 && !m_wr), "R6 oe_n", 32'(mem_oe_n), 32'(!(m_left > 0 && !m_wr)));
      chk(mem_we_n == !(m_left > 0 && m_wr && m_allow), "R7 we_n", 32'(mem_we_n), 32'(!(m_left > 0 && m_wr && m_allow)));
      chk(req_ack == m_ack, "R5 ack", 32'(req_ack), 32'(m_ack));
      chk(wr_err == m_err, "R7 err", 32'(wr_err), 32'(m_err));
      chk(req_ready == (m_left == 0), "R9 ready", 32'(req_ready), 32'(m_left == 0));
      chk(req_rdata == m_rdata, "R6 rdata", req_rdata, m_rdata);
      chk(cfg_rdata == m_crd, "R3 cfg_rdata", 32'(cfg_rdata), 32'(m_crd));
      if (m_left > 0) begin
        chk(mem_addr == m_addr, "R9 addr", 32'(mem_addr), 32'(m_addr));
        chk(mem_wdata == m_wd, "R9 wdata", mem_wdata, m_wd);
        chk(mem_be == m_be, "R9 be", 32'(mem_be), 32'(m_be));
        chk(mem_sync == m_sync, "R8 sync", 32'(mem_sync), 32'(m_sync));
        chk(mem_width == m_width, "R8 width", 32'(mem_width), 32'(m_width));
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk);
    cfg_req = 0;
    v = cfg_rdata;
  endtask

  task automatic access(input bit wr, input logic [23:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int exp_len, input bit exp_we,
                        input bit poke);
    int act_len = 0, we_len = 0;
    bit hold_ok = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 40; i++) begin
      if (mem_cs_n != 4'hF) begin
        act_len++;
        if (mem_addr != a) hold_ok = 0;
      end
      if (!mem_we_n) we_len++;
      if (req_ack) break;
      if (poke && i == 1) begin
        req_valid = 1; req_write = 1; req_addr = a ^ 24'h40_0F0F;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    chk(act_len == exp_len, "R5 strobe length", act_len, exp_len);
    chk(we_len == (exp_we ? exp_len : 0), "R7 write strobe cycles", we_len, exp_we ? exp_len : 0);
    chk(hold_ok, "R9 address held", 32'(hold_ok), 1);
    if (!wr) chk(req_rdata == {8'hA5, a}, "R6 read data", req_rdata, {8'hA5, a});
  endtask

  // ---------------- sequence ----------------
  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready", 32'(req_ready), 1);
    chk(mem_cs_n == 4'hF, "R1 cs idle", 32'(mem_cs_n), 32'hF);
    chk(wr_err == 0, "R1 err", 32'(wr_err), 0);
    for (int k = 0; k < 4; k++) begin
      cfg_read(6'(k * 4), v);
      chk(v == 16'h00F0, "R1 cfg reset", 32'(v), 32'hF0);
    end
    cfg_read(6'h20, v); chk(v == 16'h0000, "R2 locked at reset", 32'(v), 0);

    cfg_write(6'h00, 16'h0002);
    cfg_read(6'h00, v); chk(v == 16'h00F0, "R3 locked write dropped", 32'(v), 32'hF0);
    cfg_write(6'h20, 16'h1234);
    cfg_read(6'h20, v); chk(v == 16'h0000, "R2 wrong key", 32'(v), 0);
    cfg_write(6'h20, 16'hA05F);
    cfg_read(6'h20, v); chk(v == 16'h0001, "R2 unlocked", 32'(v), 1);

    cfg_write(6'h00, 16'h000E);  // wait 0, sync, write ok, 32-bit
    cfg_write(6'h04, 16'h00F4);  // wait F, async, write ok, 8-bit
    cfg_write(6'h08, 16'h00E3);  // wait E, write off, reserved width
    cfg_write(6'h0C, 16'h0051);  // wait 5, write off, 16-bit
    cfg_read(6'h08, v); chk(v == 16'h00E3, "R3 unlocked write", 32'(v), 32'hE3);

    cfg_write(6'h20, 16'h0000);
    cfg_read(6'h20, v); chk(v == 16'h0000, "R2 relocked", 32'(v), 0);
    cfg_write(6'h0C, 16'h00FF);
    cfg_read(6'h0C, v); chk(v == 16'h0051, "R3 relocked write dropped", 32'(v), 32'h51);

    access(0, 24'h00_0123, 32'h0, 4'hF, 2, 0, 0);            // R4 R6 R8 shortest
    access(1, 24'h40_0010, 32'hDEADBEEF, 4'b0011, 16, 1, 0); // R5 saturated code F, R7
    chk(wr_err == 0, "R7 no error on allowed write", 32'(wr_err), 0);
    access(1, 24'hC0_0044, 32'h12345678, 4'b1100, 7, 0, 0);  // R7 blocked write
    chk(wr_err == 1, "R7 error raised", 32'(wr_err), 1);
    access(0, 24'h80_0200, 32'h0, 4'hF, 16, 0, 0);           // R5 code E, R8 reserved width
    access(0, 24'hC0_0ABC, 32'h0, 4'hF, 7, 0, 1);            // R9 request while busy
    repeat (3) @(negedge clk);
    chk(wr_err == 1, "R7 error sticky", 32'(wr_err), 1);
    chk(mem_cs_n == 4'hF, "R9 poke not accepted", 32'(mem_cs_n), 32'hF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule